// File: doc/BRIEF.md
# Masked Interrupt Pass-Through Bridge

This block hands a chosen set of level-sensitive interrupt lines from a source processing domain to a second, receiving domain. The source side presents its interrupts as one wide vector indexed by source interrupt number. Only three runs of that vector are bridged. A fixed remapping packs those runs into a dense range of bridge IDs, 0 to 109.

Every bridged line has one enable bit. Software sets the enable bits through a small bank of 32-bit read-write registers, on a plain register port with address, write enable, write data and read data. Each forwarded output is the live source level ANDed with its enable. Nothing is latched and no edge is detected, so a change to an enable shows on the forwarded level as soon as the register holds the new value.

Top module: `irq_bridge`

## Requirements
- R1: `fwd_irq[n]` equals `src_irq[s(n)] & enable[n]`. The map s is: bridge IDs 0–31 take source numbers 1–32, IDs 32–88 take source numbers 65–121, and IDs 89–109 take source numbers 131–151.
- R2: A write that sets an enable while its source is already high raises that output right after the clock edge that takes the write. It needs no new source event.
- R3: A write that clears an enable while its source is high drops that output right after the clock edge that takes the write.
- R4: Enable register k (k = 0..3) sits at byte address 4·k. The enable for bridge ID n is bit n mod 32 of register n div 32. A write is taken on the rising clock edge, and read data shows the addressed register combinationally.
- R5: In the register at 0x0C, bits 14–31 (bridge IDs 110 and up) always read as zero, and writes to them are dropped.
- R6: Synchronous reset clears every enable bit, so all registers read zero and every forwarded output is low.
- R7: An address that is not one of 0x00, 0x04, 0x08 or 0x0C reads as zero, and a write to it changes no register. This includes unaligned addresses and addresses at or above 0x10.
- R8: Source bit 0, source numbers 33–64 and source numbers 122–130 have no effect on any forwarded output.
- R9: A change on a source line reaches its forwarded output in the same cycle, with no clock edge needed, because no register sits on that path.
- R10: A write to one enable register leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_irq | input | 152 | Source interrupt levels, indexed by source number |
| fwd_irq | output | 110 | Forwarded interrupt levels, indexed by bridge ID |

## Verification
Two kinds of result are checked, and they fall due at different times. Register writes update the enable state at the rising edge that samples the strobe. The bench therefore drives each write on a falling edge and checks the read data and forwarded levels on the following falling edge, one clock edge later. Source levels and read addresses reach `fwd_irq` and `reg_rdata` with no clock at all. For these, the bench changes the input between edges and samples one nanosecond later, with no edge in between. This also shows that R9 holds without any register stage. The expected forwarded vector comes from the bench's own walk over the bridged source ranges and its own copy of the enables, built from the writes it has made.

// File: rtl/irq_bridge_pkg.sv
package irq_bridge_pkg;

    localparam int SRC_W      = 152;
    localparam int BRIDGE_N   = 110;
    localparam int REG_W      = 32;
    localparam int REG_N      = (BRIDGE_N + REG_W - 1) / REG_W;
    localparam int ADDR_W     = 8;
    localparam int REG_IDX_W  = (REG_N > 1) ? $clog2(REG_N) : 1;
    localparam int SEG_N      = 3;

    // first bridge ID and first source number of each packed run
    localparam int SEG_BR_LO  [SEG_N] = '{0, 32, 89};
    localparam int SEG_SRC_LO [SEG_N] = '{1, 65, 131};

    typedef logic [REG_W-1:0]     word_t;
    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef struct packed {
        addr_t addr;
        logic  we;
        word_t wdata;
    } reg_req_t;

    typedef struct packed {
        logic     hit;
        reg_idx_t idx;
    } reg_sel_t;

    // source number that feeds a given bridge ID
    function automatic int bridge_src(input int id);
        int s;
        s = SEG_SRC_LO[0] + id - SEG_BR_LO[0];
        for (int g = 1; g < SEG_N; g++) begin
            if (id >= SEG_BR_LO[g]) s = SEG_SRC_LO[g] + id - SEG_BR_LO[g];
        end
        return s;
    endfunction

    // one bit per source number that is actually bridged
    function automatic logic [SRC_W-1:0] used_src_mask();
        logic [SRC_W-1:0] m;
        m = '0;
        for (int n = 0; n < BRIDGE_N; n++) m[bridge_src(n)] = 1'b1;
        return m;
    endfunction

    // number of implemented enable bits in register k
    function automatic int live_bits(input int k);
        int r;
        r = BRIDGE_N - k * REG_W;
        if (r > REG_W) r = REG_W;
        return r;
    endfunction

endpackage

// File: rtl/irqb_addr_decode.sv
module irqb_addr_decode
    import irq_bridge_pkg::*;
(
    input  addr_t    addr,
    output reg_sel_t sel
);
    localparam int HI_W = ADDR_W - 2;
    localparam logic [HI_W-1:0] REG_N_HI = HI_W'(REG_N);

    always_comb begin
        sel.hit = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] < REG_N_HI);
        sel.idx = addr[2 +: REG_IDX_W];
    end
endmodule

// File: rtl/irqb_enable_bank.sv
module irqb_enable_bank
    import irq_bridge_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  reg_sel_t            sel,
    input  logic                we,
    input  word_t               wdata,
    output word_t               rdata,
    output logic [BRIDGE_N-1:0] enables
);
    word_t view [REG_N];

    for (genvar k = 0; k < REG_N; k++) begin : g_reg
        localparam int LIVE = live_bits(k);
        logic [LIVE-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && sel.hit && (sel.idx == REG_IDX_W'(k))) begin
                q <= wdata[LIVE-1:0];
            end
        end

        assign enables[k*REG_W +: LIVE] = q;

        if (LIVE < REG_W) begin : g_pad
            assign view[k] = {{(REG_W-LIVE){1'b0}}, q};
        end else begin : g_full
            assign view[k] = q;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel.hit) rdata = view[sel.idx];
    end
endmodule

// File: rtl/irqb_src_gather.sv
module irqb_src_gather
    import irq_bridge_pkg::*;
(
    input  logic [SRC_W-1:0]    src,
    output logic [BRIDGE_N-1:0] packed_src
);
    localparam logic [SRC_W-1:0] USED = used_src_mask();

    for (genvar n = 0; n < BRIDGE_N; n++) begin : g_pick
        assign packed_src[n] = src[bridge_src(n)];
    end

    logic unused_src;
    assign unused_src = ^(src & ~USED);
endmodule

// File: rtl/irqb_gate.sv
module irqb_gate
    import irq_bridge_pkg::*;
(
    input  logic [BRIDGE_N-1:0] level,
    input  logic [BRIDGE_N-1:0] enables,
    output logic [BRIDGE_N-1:0] fwd
);
    for (genvar n = 0; n < BRIDGE_N; n++) begin : g_and
        assign fwd[n] = level[n] & enables[n];
    end
endmodule

// File: rtl/irq_bridge.sv
module irq_bridge
    import irq_bridge_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          reg_addr,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [151:0]        src_irq,
    output logic [109:0]        fwd_irq
);
    reg_req_t            req;
    reg_sel_t            sel;
    logic [BRIDGE_N-1:0] en;
    logic [BRIDGE_N-1:0] lvl;

    assign req = '{addr: reg_addr, we: reg_we, wdata: reg_wdata};

    irqb_addr_decode u_dec (
        .addr (req.addr),
        .sel  (sel)
    );

    irqb_enable_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .we      (req.we),
        .wdata   (req.wdata),
        .rdata   (reg_rdata),
        .enables (en)
    );

    irqb_src_gather u_gather (
        .src        (src_irq),
        .packed_src (lvl)
    );

    irqb_gate u_gate (
        .level   (lvl),
        .enables (en),
        .fwd     (fwd_irq)
    );
endmodule

// File: rtl/irq_bridge_chk.sv
module irq_bridge_chk
    import irq_bridge_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic [7:0]   reg_addr,
    input logic         reg_we,
    input logic [31:0]  reg_wdata,
    input logic [31:0]  reg_rdata,
    input logic [151:0] src_irq,
    input logic [109:0] fwd_irq
);
    // R1: a forwarded line is never high unless its mapped source is high
    for (genvar i = 0; i < BRIDGE_N; i++) begin : g_src
        p_fwd_needs_src_r1: assert property (@(posedge clk) disable iff (rst)
            fwd_irq[i] |-> src_irq[bridge_src(i)]);
    end

    // R2, R3: a write to register 0 takes effect on the level at once
    p_enable_applies_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && !$past(rst) && $past(reg_addr) == 8'h00)
        |-> (fwd_irq[31:0] == ($past(reg_wdata) & src_irq[32:1])));

    // R4: register 0 reads back what was written to it
    p_readback_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && !$past(rst) && $past(reg_addr) == 8'h00 && reg_addr == 8'h00)
        |-> (reg_rdata == $past(reg_wdata)));

    // R5: bits above bridge ID 109 always read zero
    p_top_bits_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h0C) |-> (reg_rdata[31:14] == 18'h0));

    // R6: the cycle after reset nothing is forwarded
    p_reset_clears_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fwd_irq == '0));

    // R7: an address outside the bank reads zero
    p_oor_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[1:0] != 2'b00 || reg_addr >= 8'h10) |-> (reg_rdata == '0));
endmodule

bind irq_bridge irq_bridge_chk u_chk (.*);

// File: tb/irq_bridge_bench.sv
module irq_bridge_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic [7:0]   reg_addr;
    logic         reg_we;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic [151:0] src_irq;
    logic [109:0] fwd_irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [109:0] en_model;

    always #2 clk = ~clk;

    irq_bridge u_irq_bridge (.*);

    // vector: byte address, write data, expected read-back
    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'hA5A5_F00F, 32'hA5A5_F00F},
        '{8'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{8'h08, 32'h1234_5678, 32'h1234_5678},
        '{8'h0C, 32'hFFFF_FFFF, 32'h0000_3FFF},
        '{8'h0C, 32'hC000_2001, 32'h0000_2001},
        '{8'h10, 32'hDEAD_BEEF, 32'h0000_0000},
        '{8'h02, 32'hFFFF_FFFF, 32'h0000_0000},
        '{8'h41, 32'h5555_5555, 32'h0000_0000},
        '{8'hFC, 32'h0F0F_0F0F, 32'h0000_0000}
    };

    // independent map: walk source numbers, skipping the unbridged runs
    function automatic logic [109:0] exp_fwd(input logic [151:0] s, input logic [109:0] e);
        logic [109:0] r;
        int id;
        r  = '0;
        id = 0;
        for (int sn = 1; sn < 152; sn++) begin
            if (!((sn >= 33 && sn <= 64) || (sn >= 122 && sn <= 130))) begin
                r[id] = s[sn] & e[id];
                id++;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] model_reg(input int k);
        logic [31:0] w;
        w = '0;
        for (int b = 0; b < 32; b++) if (k*32 + b < 110) w[b] = en_model[k*32 + b];
        return w;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_fwd(input string req);
        logic [109:0] e;
        e = exp_fwd(src_irq, en_model);
        n_vec++;
        if (fwd_irq !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, fwd_irq, e);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a[1:0] == 2'b00 && a < 8'h10) begin
            for (int b = 0; b < 32; b++)
                if (int'(a[7:2])*32 + b < 110) en_model[int'(a[7:2])*32 + b] = d[b];
        end
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check32(req, reg_rdata, exp);
    endtask

    initial begin
        #400000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        reg_addr  = '0;
        reg_we    = 1'b0;
        reg_wdata = '0;
        src_irq   = '1;
        en_model  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R6: reset state
        check_fwd("R6 fwd after reset");
        for (int k = 0; k < 4; k++) rd_check("R6 reg after reset", 8'(4*k), 32'h0);

        // table walk: R4, R5, R7
        for (int v = 0; v < NV; v++) begin
            wr(VECS[v].a, VECS[v].d);
            rd_check("R4/R5/R7 readback", VECS[v].a, VECS[v].rd);
        end

        // R10 and R7: every register still holds its own last write
        for (int k = 0; k < 4; k++) rd_check("R10 R7 registers intact", 8'(4*k), model_reg(k));

        // R1 under several source patterns
        src_irq = '1;                          #1; check_fwd("R1 all sources high");
        src_irq = {76{2'b10}};                 #1; check_fwd("R1 alternating sources");
        src_irq = 152'h00C3_5A00_FF01_2345_6789_ABCD_EF01_2345_6789_ABCD;
        #1; check_fwd("R1 mixed sources");

        // R8: only unbridged positions high
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
        src_irq = '0;
        src_irq[0] = 1'b1;
        src_irq[64:33] = '1;
        src_irq[130:122] = '1;
        #1; check_fwd("R8 unbridged sources ignored");
        check32("R8 no output", 32'(fwd_irq != '0), 32'h0);

        // R9: level follows source with no clock edge
        @(negedge clk);
        src_irq = '0;
        src_irq[131] = 1'b1;
        #1; check32("R9 same-cycle rise", {31'h0, fwd_irq[89]}, 32'h1);
        src_irq[131] = 1'b0;
        #1; check32("R9 same-cycle fall", {31'h0, fwd_irq[89]}, 32'h0);

        // R2: enable set while source already high
        wr(8'h04, 32'h0);
        src_irq = '1;
        #1; check32("R2 gated before enable", {31'h0, fwd_irq[40]}, 32'h0);
        wr(8'h04, 32'h0000_0100);
        #1; check32("R2 rises on enable", {31'h0, fwd_irq[40]}, 32'h1);
        check_fwd("R2 full vector");

        // R3: enable cleared while source high
        wr(8'h04, 32'h0);
        #1; check32("R3 drops on disable", {31'h0, fwd_irq[40]}, 32'h0);
        check_fwd("R3 full vector");

        // R6: reset mid-run clears all enables
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        en_model = '0;
        #1; check_fwd("R6 fwd after second reset");
        for (int k = 0; k < 4; k++) rd_check("R6 reg after second reset", 8'(4*k), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule